// File: doc/BRIEF.md
# Calendar Alarm Match Unit

This unit watches a live BCD calendar (seconds, minutes, hours, weekday, day, month, year) supplied on input ports by an external time counter, and compares it against a programmed alarm time. Each of the seven alarm fields has its own participation flag. A field whose flag is clear is left out of the comparison. The weekday field is normally programmed with its flag clear.

Software programs the alarm through a small write port. The seven field values are first written into a staging set. They take effect together only when a commit word is written. The compare is evaluated once per second tick. When every participating field equals the current time, a sticky status bit is set. A separate enable bit gates that status onto a level interrupt output. The status bit is cleared by writing a one to it. If a set and a clear fall in the same cycle, the set wins.

Register map (16-bit words):
- Addresses 0 to 6 are the alarm fields: seconds, minutes, hours, weekday, day, month, year.
- Address 7 is the commit word.
- Address 8 is the interrupt enable.
- Address 9 is the interrupt status.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset, all staged and active alarm fields and their flags are zero, the interrupt enable and the status are zero, and `irq` is low.
- R2: A write to addresses 0..6 changes only the staging set. Reads of addresses 0..6 return the active set as `{flag, 7'b0, value}`, where the value sits in bits 7:0 and the flag in bit 15. A staged change alters neither the read value nor the match until a commit.
- R3: A write to address 7 with bit 15 set copies all seven staged fields and flags into the active set in one cycle. A write to address 7 with bit 15 clear has no effect.
- R4: Each field keeps only its low bits: 7 for seconds, 7 for minutes, 6 for hours, 3 for weekday, 6 for day, 5 for month, and 8 for year. Bit 15 is kept as the flag. All other written bits read back as zero. The current-time inputs are compared through the same field widths.
- R5: On a clock edge where `tick` is high, at least one active flag is set, and every flagged field equals the current time, the status bit (address 9, bit 0) reads 1 after that edge. It then stays 1 through later ticks that do not match.
- R6: With no active flag set, the status never sets, whatever the time inputs are.
- R7: Without `tick`, a match does not set the status.
- R8: A write to address 9 with bit 0 set clears the status. A write with bit 0 clear leaves it unchanged.
- R9: When a setting tick and a clearing write occur in the same cycle, the status ends up set.
- R10: `irq` is high exactly while both the status bit and the enable bit (address 8, bit 0) are 1. The enable bit is written and read at address 8, bit 0.
- R11: A field whose active flag is clear is ignored by the match, whatever its stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse per second, sampling the time inputs |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 6 | Current hours, BCD |
| now_wday | input | 3 | Current weekday |
| now_day | input | 6 | Current day of month, BCD |
| now_mon | input | 5 | Current month, BCD |
| now_year | input | 8 | Current year, BCD |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Register read data, combinational |
| irq | output | 1 | Level alarm interrupt |

## Verification
The assertions assume that `tick` and the register write port are the only agents that move the status and the active set. They also assume that the write address and data are stable and defined whenever `wr_en` is high. The bench drives every input only on the falling edge. It raises `tick` for single cycles only, and it issues at most one write per cycle. It never writes an address above 9, so the set and clear conditions seen by the checker are always those the bench intends.

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int NFIELD = 7,
  parameter int VW     = 8,
  parameter int DW     = 16,
  parameter int AW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [6:0]    now_sec,
  input  logic [6:0]    now_min,
  input  logic [5:0]    now_hour,
  input  logic [2:0]    now_wday,
  input  logic [5:0]    now_day,
  input  logic [4:0]    now_mon,
  input  logic [7:0]    now_year,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          irq
);
  localparam int ADDR_COMMIT = NFIELD;
  localparam int ADDR_IE     = NFIELD + 1;
  localparam int ADDR_STS    = NFIELD + 2;
  localparam int FLAG_BIT    = DW - 1;

  function automatic logic [VW-1:0] field_mask(input int idx);
    case (idx)
      0, 1:    field_mask = 8'h7F;
      2, 4:    field_mask = 8'h3F;
      3:       field_mask = 8'h07;
      5:       field_mask = 8'h1F;
      default: field_mask = 8'hFF;
    endcase
  endfunction

  logic [VW-1:0] stg_val [NFIELD];
  logic [VW-1:0] act_val [NFIELD];
  logic [VW-1:0] cur     [NFIELD];
  logic [NFIELD-1:0] stg_en, act_en, eq;
  logic ie_q, sts_q, hit, commit, clr;

  assign cur[0] = VW'(now_sec);
  assign cur[1] = VW'(now_min);
  assign cur[2] = VW'(now_hour);
  assign cur[3] = VW'(now_wday);
  assign cur[4] = VW'(now_day);
  assign cur[5] = VW'(now_mon);
  assign cur[6] = VW'(now_year);

  assign commit = wr_en && wr_addr == AW'(ADDR_COMMIT) && wr_data[FLAG_BIT];
  assign clr    = wr_en && wr_addr == AW'(ADDR_STS) && wr_data[0];

  for (genvar i = 0; i < NFIELD; i++) begin : g_field
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_val[i] <= '0;
        stg_en[i]  <= 1'b0;
      end else if (wr_en && wr_addr == AW'(i)) begin
        stg_val[i] <= wr_data[VW-1:0] & field_mask(i);
        stg_en[i]  <= wr_data[FLAG_BIT];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_val[i] <= '0;
        act_en[i]  <= 1'b0;
      end else if (commit) begin
        act_val[i] <= stg_val[i];
        act_en[i]  <= stg_en[i];
      end
    end

    assign eq[i] = act_val[i] == (cur[i] & field_mask(i));
  end

  assign hit = (|act_en) && (&(~act_en | eq));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ie_q <= 1'b0;
    else if (wr_en && wr_addr == AW'(ADDR_IE)) ie_q <= wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= 1'b0;
    else if (tick && hit) sts_q <= 1'b1;
    else if (clr) sts_q <= 1'b0;
  end

  assign irq = sts_q & ie_q;

  always_comb begin
    rd_data = '0;
    if (rd_addr < AW'(NFIELD))
      rd_data = {act_en[rd_addr[2:0]], {(DW-VW-1){1'b0}}, act_val[rd_addr[2:0]]};
    else if (rd_addr == AW'(ADDR_IE))
      rd_data[0] = ie_q;
    else if (rd_addr == AW'(ADDR_STS))
      rd_data[0] = sts_q;
  end
endmodule

// File: rtl/rtc_alarm_match_chk.sv
module rtc_alarm_match_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        wr_en,
  input logic [3:0]  wr_addr,
  input logic [15:0] wr_data,
  input logic        irq,
  input logic        sts_q,
  input logic        ie_q,
  input logic        hit,
  input logic [6:0]  act_en
);
  AST_SET_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q) |-> $past(tick)); // R7
  AST_SET_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q) |-> $past(|act_en)); // R6
  AST_CLEAR_BY_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sts_q) |-> $past(wr_en && wr_addr == 4'd9 && wr_data[0])); // R8
  AST_FLAGS_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_en) |-> $past(wr_en && wr_addr == 4'd7 && wr_data[15])); // R3
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && hit && wr_en && wr_addr == 4'd9 && wr_data[0]) |=> sts_q); // R9
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sts_q && ie_q)); // R10
endmodule

bind rtc_alarm_match rtc_alarm_match_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .irq(irq), .sts_q(sts_q), .ie_q(ie_q), .hit(hit),
  .act_en(act_en)
);

// File: tb/tb_rtc_alarm_match.sv
`timescale 1ns/1ps
module tb_rtc_alarm_match;
  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0;
  logic [6:0] now_sec = 0, now_min = 0;
  logic [5:0] now_hour = 0, now_day = 0;
  logic [2:0] now_wday = 0;
  logic [4:0] now_mon = 0;
  logic [7:0] now_year = 0;
  logic [3:0] wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0, rd_data;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rtc_alarm_match dut (.*);

  localparam logic [7:0] MASKS [7] = '{8'h7F, 8'h7F, 8'h3F, 8'h07, 8'h3F, 8'h1F, 8'hFF};
  localparam logic [7:0] BASE  [7] = '{8'h45, 8'h30, 8'h17, 8'h03, 8'h21, 8'h09, 8'h26};

  function automatic logic [7:0] bcd(input int n);
    return 8'((n / 10) * 16 + (n % 10));
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pulse;
    @(negedge clk);
    tick = 1;
    @(negedge clk);
    tick = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic set_now(input logic [7:0] v [7]);
    now_sec = v[0][6:0]; now_min = v[1][6:0]; now_hour = v[2][5:0];
    now_wday = v[3][2:0]; now_day = v[4][5:0]; now_mon = v[5][4:0];
    now_year = v[6];
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [7:0] nv [7];
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      rd(4'(i), d);
      check("R1 reset regs", d, 16'h0);
    end
    check("R1 reset irq", {15'b0, irq}, 16'h0);

    wr(4'd0, 16'h8012);
    rd(4'd0, d);
    check("R2 staged not visible", d, 16'h0000);
    wr(4'd7, 16'h0000);
    rd(4'd0, d);
    check("R3 commit without bit15 ignored", d, 16'h0000);
    wr(4'd7, 16'h8000);
    rd(4'd0, d);
    check("R3 commit copies", d, 16'h8012);

    wr(4'd3, 16'hFFFF);
    wr(4'd5, 16'h7FFF);
    wr(4'd7, 16'h8000);
    rd(4'd3, d);
    check("R4 weekday mask", d, 16'h8007);
    rd(4'd5, d);
    check("R4 month mask", d, 16'h001F);

    for (int i = 0; i < 7; i++) wr(4'(i), 16'h0000);
    wr(4'd0, 16'h8012);
    wr(4'd7, 16'h8000);
    nv = BASE;
    nv[0] = 8'h12;
    set_now(nv);
    wr(4'd8, 16'h0001);
    rd(4'd8, d);
    check("R10 enable readback", d, 16'h0001);
    repeat (3) @(negedge clk);
    rd(4'd9, d);
    check("R7 no tick no set", d, 16'h0000);
    wr(4'd0, 16'h8013);
    pulse();
    rd(4'd9, d);
    check("R5 set on tick", d, 16'h0001);
    check("R10 irq high", {15'b0, irq}, 16'h0001);
    rd(4'd0, d);
    check("R2 staged 13 not yet active", d, 16'h8012);
    now_sec = 7'h13;
    pulse();
    rd(4'd9, d);
    check("R5 status sticky", d, 16'h0001);
    wr(4'd9, 16'h0000);
    rd(4'd9, d);
    check("R8 write zero keeps", d, 16'h0001);
    wr(4'd8, 16'h0000);
    check("R10 irq gated off", {15'b0, irq}, 16'h0000);
    wr(4'd8, 16'h0001);
    wr(4'd9, 16'h0001);
    rd(4'd9, d);
    check("R8 w1c clears", d, 16'h0000);
    check("R10 irq low after clear", {15'b0, irq}, 16'h0000);

    now_sec = 7'h12;
    @(negedge clk);
    tick = 1; wr_en = 1; wr_addr = 4'd9; wr_data = 16'h0001;
    @(negedge clk);
    tick = 0; wr_en = 0;
    rd(4'd9, d);
    check("R9 set beats clear", d, 16'h0001);

    for (int i = 0; i < 7; i++) wr(4'(i), {8'h00, BASE[i]});
    wr(4'd7, 16'h8000);
    wr(4'd9, 16'h0001);
    pulse();
    rd(4'd9, d);
    check("R6 no flag never sets", d, 16'h0000);

    for (int i = 0; i < 3; i++) begin
      int a = (i == 0) ? 0 : (i == 1) ? 59 : 30;
      for (int f = 1; f < 7; f++) wr(4'(f), 16'h0000);
      wr(4'd0, {8'h80, bcd(a)});
      wr(4'd7, 16'h8000);
      for (int s = 0; s < 60; s++) begin
        wr(4'd9, 16'h0001);
        now_sec = bcd(s)[6:0];
        pulse();
        rd(4'd9, d);
        check("R5 seconds sweep", d, {15'b0, s == a});
      end
    end

    set_now(BASE);
    for (int k = 0; k < 4; k++) begin
      logic [6:0] diff;
      diff = (k == 0) ? 7'h01 : (k == 1) ? 7'h08 : (k == 2) ? 7'h40 : 7'h22;
      for (int m = 0; m < 128; m++) begin
        for (int f = 0; f < 7; f++) begin
          logic [7:0] v;
          v = diff[f] ? ((BASE[f] ^ 8'h01) & MASKS[f]) : BASE[f];
          wr(4'(f), {m[f], 7'b0, v});
        end
        wr(4'd7, 16'h8000);
        wr(4'd9, 16'h0001);
        pulse();
        rd(4'd9, d);
        check("R11 flag mask sweep", d, {15'b0, (m != 0) && ((7'(m) & diff) == 0)});
        check("R10 irq in sweep", {15'b0, irq}, {15'b0, (m != 0) && ((7'(m) & diff) == 0)});
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule